// File: doc/BRIEF.md
# Dual-Clock Burst-Addressed Shared Memory

This block is a true two-port synchronous memory. A left and a right port each run on their own clock and can both reach any word, including the same word in the same cycle. Each port has a read/write select and an output enable. It also has a pair of select inputs, one active low and one active high, and both must be asserted for the port to act. A per-port mode input picks whether read data comes out of one output register (flow-through) or out of two (pipelined, one cycle later). The data bus is split into a write-data input, a read-data output and a read-valid flag.

Every port carries its own address register, which also serves as a burst counter. At each rising clock edge one counter operation is decoded, in this priority order: CTR_CLEAR (clear to zero), CTR_LOAD (load the external address), CTR_STEP (advance by one, wrapping past the last word to zero) and CTR_HOLD (keep the current value). The value the register takes at that edge is the address that edge reads or writes. This lets a port stream one word per cycle without presenting new addresses.

Each port's output logic is a small state machine. Its states are ACC_IDLE (deselected), ACC_READ and ACC_WRITE, and it moves to the state matching the access decoded at every edge. From ACC_READ it feeds the read-valid flag, directly in flow-through mode and through a second register in pipelined mode. Same-address collisions follow a fixed rule: when both ports write the same word in one cycle, the left data is kept, and a read that meets a write from the other port returns the word's previous contents. The collision rule assumes the two port clocks have coincident edges whenever both ports reach the same word. `ADDR_W` sets the depth at 2^ADDR_W words (15 to 17 for 32K to 128K words; the default is kept small). `DATA_W` is 8 or 9.

Top module: `dpram_burst_top`

## Requirements
- R1: With the port selected and `x_rnw`=0 at a rising edge, `x_din` is stored at the address the counter takes at that edge.
- R2: With `x_pipe_mode`=0, a read decoded at an edge (port selected, `x_rnw`=1) shows the word at that edge's address on `x_dout`, with `x_dout_vld`=1, from that edge until the next edge.
- R3: With `x_pipe_mode`=1, the same read result appears one clock later than in R2, and `x_dout_vld` is 0 in the cycle R2 would have shown it.
- R4: While `x_oe_n`=1, `x_dout_vld` is 0 and `x_dout` is all zeros.
- R5: A port is selected only when `x_sel_n`=0 and `x_sel`=1. When deselected, nothing is written and no read result is produced.
- R6: The counter decodes at each edge in this order. If `x_clr_n`=0 it goes to 0. Otherwise, if `x_ld_n`=0 it takes `x_addr`. Otherwise, if `x_inc_n`=0 it adds 1. Otherwise it holds. This runs whether or not the port is selected.
- R7: Stepping from address 2^ADDR_W-1 wraps the counter to address 0.
- R8: If both ports write the same address at coincident edges, the left port's data is stored.
- R9: A read colliding at the same edge with a write from the other port returns the old word. A read at the next edge returns the new word.
- R10: An access on one port never changes the other port's counter, output or read result at a different address.
- R11: `x_rst_n`=0 clears that port's counter to 0 and its read-valid pipeline to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_rst_n | input | 1 | Left port reset, active low |
| l_sel_n | input | 1 | Left select, active low |
| l_sel | input | 1 | Left select, active high |
| l_rnw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_pipe_mode | input | 1 | Left output mode: 0 flow-through, 1 pipelined |
| l_ld_n | input | 1 | Left counter load from `l_addr`, active low |
| l_inc_n | input | 1 | Left counter step, active low |
| l_clr_n | input | 1 | Left counter clear, active low |
| l_addr | input | ADDR_W | Left external address |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left read data |
| l_dout_vld | output | 1 | Left read data valid |
| r_clk | input | 1 | Right port clock |
| r_rst_n | input | 1 | Right port reset, active low |
| r_sel_n | input | 1 | Right select, active low |
| r_sel | input | 1 | Right select, active high |
| r_rnw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_pipe_mode | input | 1 | Right output mode: 0 flow-through, 1 pipelined |
| r_ld_n | input | 1 | Right counter load from `r_addr`, active low |
| r_inc_n | input | 1 | Right counter step, active low |
| r_clr_n | input | 1 | Right counter clear, active low |
| r_addr | input | ADDR_W | Right external address |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right read data |
| r_dout_vld | output | 1 | Right read data valid |

## Verification
Directed bursts fill the whole array through the left counter and read it back through the right counter. This separates a correct step-and-wrap from a counter that reloads or stalls. Targeted pairs of same-cycle accesses to one word tell the left-wins write rule apart from right-wins, and read-old from read-new. Explicit flow-through and pipelined reads of a single word pin the output one cycle apart. A long random mix then varies the counter controls, selects, output enable and mode of both ports together, with addresses crowded into eight words to provoke collisions. That mix is compared each cycle against a bench model of both ports.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        CTR_CLEAR,
        CTR_LOAD,
        CTR_STEP,
        CTR_HOLD
    } ctr_op_e;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE
    } acc_e;

    // Counter control priority: clear, then load, then step, then hold.
    function automatic ctr_op_e ctr_decode(input logic clr_n,
                                           input logic ld_n,
                                           input logic inc_n);
        if (!clr_n)      return CTR_CLEAR;
        else if (!ld_n)  return CTR_LOAD;
        else if (!inc_n) return CTR_STEP;
        else             return CTR_HOLD;
    endfunction

endpackage

// File: rtl/dpram_addr_ctr.sv
module dpram_addr_ctr
    import dpram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          ld_n,
    input  logic          inc_n,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] cur_addr
);

    ctr_op_e op;

    assign op = ctr_decode(clr_n, ld_n, inc_n);

    // Address the coming edge accesses; also the counter's next value.
    always_comb begin
        unique case (op)
            CTR_CLEAR: eff_addr = '0;
            CTR_LOAD:  eff_addr = ext_addr;
            CTR_STEP:  eff_addr = cur_addr + AW'(1);
            default:   eff_addr = cur_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_addr <= '0;
        else        cur_addr <= eff_addr;
    end

endmodule

// File: rtl/dpram_array.sv
module dpram_array #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          l_clk,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_din,
    output logic [DW-1:0] l_rdata,
    input  logic          r_clk,
    input  logic          r_we,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_din,
    output logic [DW-1:0] r_rdata
);

    localparam int DEPTH = 1 << AW;

    // One bank per writing clock. A tag pair per word records the last
    // writer: equal tags select the left bank, unequal the right bank.
    logic [DW-1:0]    bank_l [DEPTH];
    logic [DW-1:0]    bank_r [DEPTH];
    logic [DEPTH-1:0] tag_l;
    logic [DEPTH-1:0] tag_r;
    logic             r_we_eff;

    // Same word written by both ports at one edge: left is kept.
    assign r_we_eff = r_we && !(l_we && (l_addr == r_addr));

    always_ff @(posedge l_clk) begin
        if (l_we) begin
            bank_l[l_addr] <= l_din;
            tag_l[l_addr]  <= tag_r[l_addr];
        end
    end

    always_ff @(posedge r_clk) begin
        if (r_we_eff) begin
            bank_r[r_addr] <= r_din;
            tag_r[r_addr]  <= ~tag_l[r_addr];
        end
    end

    assign l_rdata = (tag_l[l_addr] == tag_r[l_addr]) ? bank_l[l_addr] : bank_r[l_addr];
    assign r_rdata = (tag_l[r_addr] == tag_r[r_addr]) ? bank_l[r_addr] : bank_r[r_addr];

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out
    import dpram_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          rnw,
    input  logic          pipe_mode,
    input  logic          oe_n,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] dout,
    output logic          dout_vld
);

    acc_e          acc_d;
    acc_e          acc_q;
    logic [DW-1:0] stage1_q;
    logic [DW-1:0] stage2_q;
    logic          stage2_vld_q;
    logic          ft_ready;
    logic          ready;

    always_comb begin
        if (!go)      acc_d = ACC_IDLE;
        else if (rnw) acc_d = ACC_READ;
        else          acc_d = ACC_WRITE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= ACC_IDLE;
        else        acc_q <= acc_d;
    end

    // Read data registers: first stage captures the word, second delays it.
    always_ff @(posedge clk) begin
        if (acc_d == ACC_READ) stage1_q <= rdata;
        stage2_q <= stage1_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage2_vld_q <= 1'b0;
        else        stage2_vld_q <= (acc_q == ACC_READ);
    end

    // Output process.
    always_comb begin
        unique case (acc_q)
            ACC_READ:  ft_ready = 1'b1;
            ACC_WRITE: ft_ready = 1'b0;
            ACC_IDLE:  ft_ready = 1'b0;
            default:   ft_ready = 1'b0;
        endcase
        ready    = pipe_mode ? stage2_vld_q : ft_ready;
        dout_vld = ready && !oe_n;
        dout     = dout_vld ? (pipe_mode ? stage2_q : stage1_q) : '0;
    end

endmodule

// File: rtl/dpram_burst_top.sv
module dpram_burst_top #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              l_clk,
    input  logic              l_rst_n,
    input  logic              l_sel_n,
    input  logic              l_sel,
    input  logic              l_rnw,
    input  logic              l_oe_n,
    input  logic              l_pipe_mode,
    input  logic              l_ld_n,
    input  logic              l_inc_n,
    input  logic              l_clr_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_din,
    output logic [DATA_W-1:0] l_dout,
    output logic              l_dout_vld,
    input  logic              r_clk,
    input  logic              r_rst_n,
    input  logic              r_sel_n,
    input  logic              r_sel,
    input  logic              r_rnw,
    input  logic              r_oe_n,
    input  logic              r_pipe_mode,
    input  logic              r_ld_n,
    input  logic              r_inc_n,
    input  logic              r_clr_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_din,
    output logic [DATA_W-1:0] r_dout,
    output logic              r_dout_vld
);

    logic [ADDR_W-1:0] l_eff, r_eff;
    logic [ADDR_W-1:0] l_cur, r_cur;
    logic [DATA_W-1:0] l_rdata, r_rdata;
    logic              l_go, r_go;
    logic              l_we, r_we;

    assign l_go = l_rst_n && !l_sel_n && l_sel;
    assign r_go = r_rst_n && !r_sel_n && r_sel;
    assign l_we = l_go && !l_rnw;
    assign r_we = r_go && !r_rnw;

    dpram_addr_ctr #(.AW(ADDR_W)) u_lctr (
        .clk(l_clk), .rst_n(l_rst_n), .clr_n(l_clr_n), .ld_n(l_ld_n),
        .inc_n(l_inc_n), .ext_addr(l_addr), .eff_addr(l_eff), .cur_addr(l_cur)
    );

    dpram_addr_ctr #(.AW(ADDR_W)) u_rctr (
        .clk(r_clk), .rst_n(r_rst_n), .clr_n(r_clr_n), .ld_n(r_ld_n),
        .inc_n(r_inc_n), .ext_addr(r_addr), .eff_addr(r_eff), .cur_addr(r_cur)
    );

    dpram_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
        .l_clk(l_clk), .l_we(l_we), .l_addr(l_eff), .l_din(l_din), .l_rdata(l_rdata),
        .r_clk(r_clk), .r_we(r_we), .r_addr(r_eff), .r_din(r_din), .r_rdata(r_rdata)
    );

    dpram_port_out #(.DW(DATA_W)) u_lout (
        .clk(l_clk), .rst_n(l_rst_n), .go(l_go), .rnw(l_rnw),
        .pipe_mode(l_pipe_mode), .oe_n(l_oe_n), .rdata(l_rdata),
        .dout(l_dout), .dout_vld(l_dout_vld)
    );

    dpram_port_out #(.DW(DATA_W)) u_rout (
        .clk(r_clk), .rst_n(r_rst_n), .go(r_go), .rnw(r_rnw),
        .pipe_mode(r_pipe_mode), .oe_n(r_oe_n), .rdata(r_rdata),
        .dout(r_dout), .dout_vld(r_dout_vld)
    );

endmodule

// File: rtl/dpram_checker.sv
module dpram_checker #(
    parameter int AW = 8
) (
    input logic          l_clk,
    input logic          l_rst_n,
    input logic          l_sel_n,
    input logic          l_sel,
    input logic          l_rnw,
    input logic          l_oe_n,
    input logic          l_pipe_mode,
    input logic          l_ld_n,
    input logic          l_inc_n,
    input logic          l_clr_n,
    input logic [AW-1:0] l_addr,
    input logic          l_dout_vld,
    input logic [AW-1:0] l_cur,
    input logic          r_clk,
    input logic          r_rst_n,
    input logic          r_oe_n,
    input logic          r_clr_n,
    input logic          r_dout_vld,
    input logic [AW-1:0] r_cur
);

    logic l_rd_go;
    logic l_desel;

    assign l_rd_go = l_rst_n && !l_sel_n && l_sel && l_rnw;
    assign l_desel = l_rst_n && (l_sel_n || !l_sel);

    assert_ctr_clear_R6: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        !l_clr_n |=> (l_cur == '0));

    assert_ctr_load_R6: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        (l_clr_n && !l_ld_n) |=> (l_cur == $past(l_addr)));

    assert_ctr_step_R7: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        (l_clr_n && l_ld_n && !l_inc_n) |=> (l_cur == AW'($past(l_cur) + 1'b1)));

    assert_ctr_hold_R6: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        (l_clr_n && l_ld_n && l_inc_n) |=> $stable(l_cur));

    assert_oe_gate_R4: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        l_oe_n |-> !l_dout_vld);

    assert_flow_latency_R2: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        l_rd_go |=> (l_pipe_mode || l_oe_n || l_dout_vld));

    assert_pipe_latency_R3: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        l_rd_go |=> ##1 (!l_pipe_mode || l_oe_n || l_dout_vld));

    assert_deselect_R5: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        l_desel |=> (l_pipe_mode || !l_dout_vld));

    assert_right_clear_R6: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        !r_clr_n |=> (r_cur == '0));

    assert_right_oe_R4: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        r_oe_n |-> !r_dout_vld);

endmodule

bind dpram_burst_top dpram_checker #(.AW(ADDR_W)) u_chk (
    .l_clk(l_clk), .l_rst_n(l_rst_n), .l_sel_n(l_sel_n), .l_sel(l_sel),
    .l_rnw(l_rnw), .l_oe_n(l_oe_n), .l_pipe_mode(l_pipe_mode), .l_ld_n(l_ld_n),
    .l_inc_n(l_inc_n), .l_clr_n(l_clr_n), .l_addr(l_addr), .l_dout_vld(l_dout_vld),
    .l_cur(l_cur), .r_clk(r_clk), .r_rst_n(r_rst_n), .r_oe_n(r_oe_n),
    .r_clr_n(r_clr_n), .r_dout_vld(r_dout_vld), .r_cur(r_cur)
);

// File: tb/test_dpram_burst_top.sv
module test_dpram_burst_top;

    localparam int AW    = 8;
    localparam int DW    = 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic [1:0]         sel_n, sel, rnw, oe_n, pmode, ld_n, inc_n, clr_n, vld;
    logic [1:0][AW-1:0] addr;
    logic [1:0][DW-1:0] din, dout;

    // Bench model of both ports.
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] cur [2];
    logic [DW-1:0] rd1 [2];
    logic [DW-1:0] rd2 [2];
    logic          v1  [2];
    logic          v2  [2];
    int checks = 0;
    int errors = 0;

    dpram_burst_top #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_burst_top (
        .l_clk(clk), .l_rst_n(rst_n), .l_sel_n(sel_n[0]), .l_sel(sel[0]),
        .l_rnw(rnw[0]), .l_oe_n(oe_n[0]), .l_pipe_mode(pmode[0]), .l_ld_n(ld_n[0]),
        .l_inc_n(inc_n[0]), .l_clr_n(clr_n[0]), .l_addr(addr[0]), .l_din(din[0]),
        .l_dout(dout[0]), .l_dout_vld(vld[0]),
        .r_clk(clk), .r_rst_n(rst_n), .r_sel_n(sel_n[1]), .r_sel(sel[1]),
        .r_rnw(rnw[1]), .r_oe_n(oe_n[1]), .r_pipe_mode(pmode[1]), .r_ld_n(ld_n[1]),
        .r_inc_n(inc_n[1]), .r_clr_n(clr_n[1]), .r_addr(addr[1]), .r_din(din[1]),
        .r_dout(dout[1]), .r_dout_vld(vld[1])
    );

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 37 + 5) % (1 << DW));
    endfunction

    function automatic logic [AW-1:0] next_addr(input int p);
        if (!clr_n[p])      return '0;
        else if (!ld_n[p])  return addr[p];
        else if (!inc_n[p]) return cur[p] + AW'(1);
        else                return cur[p];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_all();
        for (int p = 0; p < 2; p++) begin
            sel_n[p] = 1'b1; sel[p] = 1'b0; rnw[p] = 1'b1; oe_n[p] = 1'b0;
            pmode[p] = 1'b0; ld_n[p] = 1'b1; inc_n[p] = 1'b1; clr_n[p] = 1'b1;
            addr[p] = '0; din[p] = '0;
        end
    endtask

    task automatic acc(input int p, input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        sel_n[p] = 1'b0; sel[p] = 1'b1; rnw[p] = !wr; ld_n[p] = 1'b0;
        inc_n[p] = 1'b1; clr_n[p] = 1'b1; addr[p] = a; din[p] = d;
    endtask

    // Advance one edge: update the model, then compare both ports.
    task automatic step(input string tag);
        logic [AW-1:0] ea [2];
        logic          s  [2];
        logic [DW-1:0] old[2];
        for (int p = 0; p < 2; p++) begin
            ea[p]  = next_addr(p);
            s[p]   = !sel_n[p] && sel[p];
            old[p] = mem[ea[p]];
        end
        if (s[1] && !rnw[1] && !(s[0] && !rnw[0] && ea[0] == ea[1])) mem[ea[1]] = din[1];
        if (s[0] && !rnw[0]) mem[ea[0]] = din[0];
        for (int p = 0; p < 2; p++) begin
            v2[p]  = v1[p];
            rd2[p] = rd1[p];
            v1[p]  = s[p] && rnw[p];
            if (s[p] && rnw[p]) rd1[p] = old[p];
            cur[p] = ea[p];
        end
        @(posedge clk); #1;
        for (int p = 0; p < 2; p++) begin
            logic          ev;
            logic [DW-1:0] ed;
            string         t;
            ev = (pmode[p] ? v2[p] : v1[p]) && !oe_n[p];
            ed = ev ? (pmode[p] ? rd2[p] : rd1[p]) : '0;
            t  = (tag != "") ? tag : (oe_n[p] ? "R4" : (pmode[p] ? "R3" : "R2"));
            check({vld[p], dout[p]} == {ev, ed}, t, p ? "right vld/dout" : "left vld/dout",
                  32'({vld[p], dout[p]}), 32'({ev, ed}));
        end
    endtask

    task automatic do_reset();
        idle_all();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        for (int p = 0; p < 2; p++) begin
            cur[p] = '0; v1[p] = 1'b0; v2[p] = 1'b0; rd1[p] = '0; rd2[p] = '0;
        end
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        check(vld == 2'b00, "R11", "valid after reset", 32'(vld), 32'd0);

        // R1/R6: fill the array with a left-port burst from address 0.
        acc(0, 1'b1, '0, pat(0)); ld_n[0] = 1'b1; clr_n[0] = 1'b0;
        step("R1");
        clr_n[0] = 1'b1; inc_n[0] = 1'b0;
        for (int i = 1; i < DEPTH; i++) begin
            din[0] = pat(i);
            step("R1");
        end
        idle_all();
        acc(1, 1'b0, '0, '0); ld_n[1] = 1'b1; clr_n[1] = 1'b0;
        step("R1");
        check(dout[1] == pat(0), "R1", "right read word 0", 32'(dout[1]), 32'(pat(0)));
        clr_n[1] = 1'b1; inc_n[1] = 1'b0;
        step("R6");
        check(dout[1] == pat(1), "R6", "right step read word 1", 32'(dout[1]), 32'(pat(1)));

        // R11: reset clears the counter (left was at the last word).
        do_reset();
        acc(0, 1'b0, '0, '0); ld_n[0] = 1'b1;
        step("R11");
        check(dout[0] == pat(0), "R11", "hold read after reset", 32'(dout[0]), 32'(pat(0)));

        // R7: wrap from the last word to word 0.
        idle_all();
        acc(0, 1'b1, AW'(DEPTH - 1), 9'h1AA);
        step("R7");
        ld_n[0] = 1'b1; inc_n[0] = 1'b0; din[0] = 9'h0CC;
        step("R7");
        acc(0, 1'b0, '0, '0); ld_n[0] = 1'b1; clr_n[0] = 1'b0;
        step("R7");
        check(dout[0] == 9'h0CC, "R7", "wrapped word 0", 32'(dout[0]), 32'h0CC);
        acc(0, 1'b0, AW'(DEPTH - 1), '0);
        step("R6");
        check(dout[0] == 9'h1AA, "R6", "loaded last word", 32'(dout[0]), 32'h1AA);

        // R8: both ports write word 5 at one edge.
        idle_all();
        acc(0, 1'b1, 8'd5, 9'h011); acc(1, 1'b1, 8'd5, 9'h122);
        step("R8");
        idle_all(); acc(0, 1'b0, 8'd5, '0);
        step("R8");
        check(dout[0] == 9'h011, "R8", "left data kept", 32'(dout[0]), 32'h011);

        // R9: right reads word 6 while left writes it.
        idle_all();
        acc(0, 1'b1, 8'd6, 9'h0F0); acc(1, 1'b0, 8'd6, '0);
        step("R9");
        check(dout[1] == pat(6), "R9", "old word on collision", 32'(dout[1]), 32'(pat(6)));
        idle_all(); acc(1, 1'b0, 8'd6, '0);
        step("R9");
        check(dout[1] == 9'h0F0, "R9", "new word next read", 32'(dout[1]), 32'h0F0);

        // R10: right writes word 9 while left reads word 10.
        idle_all();
        acc(0, 1'b0, 8'd10, '0); acc(1, 1'b1, 8'd9, 9'h155);
        step("R10");
        check(dout[0] == pat(10), "R10", "left unaffected", 32'(dout[0]), 32'(pat(10)));

        // R5: deselected write and read.
        idle_all(); acc(0, 1'b1, 8'd7, 9'h1FF); sel[0] = 1'b0;
        step("R5");
        idle_all(); acc(0, 1'b0, 8'd7, '0); sel_n[0] = 1'b1;
        step("R5");
        check(vld[0] == 1'b0, "R5", "no read when deselected", 32'(vld[0]), 32'd0);
        idle_all(); acc(0, 1'b0, 8'd7, '0);
        step("R5");
        check(dout[0] == pat(7), "R5", "word 7 unchanged", 32'(dout[0]), 32'(pat(7)));

        // R3: pipelined read one cycle later.
        idle_all();
        step("R3");
        acc(0, 1'b0, 8'd7, '0); pmode[0] = 1'b1;
        step("R3");
        check(vld[0] == 1'b0, "R3", "not valid at flow-through time", 32'(vld[0]), 32'd0);
        idle_all(); pmode[0] = 1'b1;
        step("R3");
        check({vld[0], dout[0]} == {1'b1, pat(7)}, "R3", "pipelined result",
              32'({vld[0], dout[0]}), 32'({1'b1, pat(7)}));

        // R4: output enable high blocks the result.
        idle_all(); acc(0, 1'b0, 8'd7, '0); oe_n[0] = 1'b1;
        step("R4");
        check({vld[0], dout[0]} == '0, "R4", "disabled output", 32'({vld[0], dout[0]}), 32'd0);

        // Random mix on both ports against the model.
        for (int n = 0; n < 3000; n++) begin
            for (int p = 0; p < 2; p++) begin
                sel_n[p] = ($urandom % 8) == 0;
                sel[p]   = ($urandom % 8) != 0;
                rnw[p]   = $urandom % 2;
                oe_n[p]  = ($urandom % 6) == 0;
                pmode[p] = $urandom % 2;
                clr_n[p] = ($urandom % 16) != 0;
                ld_n[p]  = ($urandom % 3) != 0;
                inc_n[p] = $urandom % 2;
                addr[p]  = ($urandom % 2) ? AW'($urandom % 8) : AW'($urandom);
                din[p]   = DW'($urandom);
            end
            step("");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule